// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences a small microcontroller into and out of its low-power stop states. When the CPU raises a one-cycle stop request, the block reads the configuration bits and picks one of three stop depths. It can also refuse the request and raise an illegal-opcode reset. While a stop state is active it drives the power-domain controls: the clock run enable, core power, RAM power and RAM standby, I/O hold, I/O reset, oscillator enable, regulator standby and comparator enable.

The block watches the wakeup pins through a synchronizer. Which pins can wake it depends on their enables, and the depth decides how it leaves the stop state. The deepest state ends in a reset equivalent to power-on. The middle state ends in a plain reset, and the block then holds the I/O pins and raises a status flag until software clears it. The lightest state resumes without a reset unless the reset pin woke it.

States: RUN, STOP1, STOP2, STOP3, WAKE_RST (reset pulse after a wakeup) and ILL_RST (illegal-opcode reset pulse).

Transitions:
- RUN to STOP1, STOP2, STOP3 or ILL_RST when a stop is requested.
- STOP1 or STOP2 to WAKE_RST on any wakeup.
- STOP3 to RUN on a pin wakeup.
- STOP3 to WAKE_RST on a reset-pin wakeup.
- WAKE_RST or ILL_RST to RUN after RST_CYCLES cycles.

Top module: `stopseq_top`

## Requirements
- R1: A stop request in RUN while cfg_stop_en=0 enters no stop state. Instead illegal_o and cpu_rst_o are high for RST_CYCLES cycles, with mode_o=0, and then the block returns to RUN.
- R2: When stop is enabled, the request is decoded as follows, with mode_o encoded 0=run, 1=stop1, 2=stop2, 3=stop3: cfg_pd=1 with cfg_ppd=0 gives stop1, cfg_pd=1 with cfg_ppd=1 gives stop2, and cfg_pd=0 gives stop3 whatever cfg_ppd is. The new mode shows one cycle after the request.
- R3: While cfg_lvd_rst_en=1, a request that would select stop1 or stop2 enters stop3 instead.
- R4: clk_run_o is 0 in every stop state and 1 otherwise, including after reset.
- R5: In stop1: core_on_o=0, ram_on_o=0, ram_stby_o=0, io_hold_o=0, io_reset_o=1, osc_on_o=0, reg_stby_o=1, cmp_on_o=0.
- R6: In stop2: core_on_o=0, ram_on_o=1, ram_stby_o=1, io_hold_o=1, io_reset_o=0, osc_on_o=0, reg_stby_o=1, cmp_on_o=0.
- R7: In stop3: core_on_o=1, ram_on_o=1, ram_stby_o=1, io_hold_o=1, io_reset_o=0, reg_stby_o=1. osc_on_o and cmp_on_o equal cfg_osc_keep and cfg_cmp_keep as sampled at the moment of entry; later changes to those inputs have no effect.
- R8: A stop state is left only by an enabled interrupt or keyboard pin at its active level, or by rst_pin_n low. A disabled pin has no effect. The state changes SYNC_STAGES+1 clock edges after the pin is driven.
- R9: In stop1, the interrupt and keyboard pins wake on a low level whatever irq_pol_high and kbi_pol_high say. In the other stop states, a high level is active when the polarity bit is 1.
- R10: A wakeup from stop1 gives cpu_rst_o=1, por_o=1 and io_reset_o=1 for RST_CYCLES cycles. por_o is never raised for any other cause.
- R11: In stop3, an interrupt or keyboard wakeup returns to RUN with cpu_rst_o=0. A reset-pin wakeup gives cpu_rst_o=1 with por_o=0.
- R12: A wakeup from stop2 gives cpu_rst_o=1 and por_o=0, and sets stop2_flag_o. While the flag is set, io_hold_o stays 1, also in RUN. A hold_clr pulse clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset of the controller |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| cfg_stop_en | input | 1 | Stop permitted |
| cfg_pd | input | 1 | Power-down select |
| cfg_ppd | input | 1 | Partial power-down select |
| cfg_lvd_rst_en | input | 1 | Low-voltage reset enabled (blocks deep stop) |
| cfg_osc_keep | input | 1 | Keep oscillator on in stop3 |
| cfg_cmp_keep | input | 1 | Keep comparator on in stop3 |
| hold_clr | input | 1 | Clears the stop2 status flag and I/O hold |
| wake_irq_en | input | 1 | Interrupt pin wakeup enable |
| wake_kbi_en | input | N_KBI | Keyboard pin wakeup enables |
| irq_pol_high | input | 1 | Interrupt pin active high (not used in stop1) |
| kbi_pol_high | input | 1 | Keyboard pins active high (not used in stop1) |
| irq_pin | input | 1 | Interrupt pin |
| kbi_pin | input | N_KBI | Keyboard pins |
| rst_pin_n | input | 1 | External reset pin, active low |
| mode_o | output | 2 | 0 run, 1 stop1, 2 stop2, 3 stop3 |
| clk_run_o | output | 1 | Internal clocks running |
| core_on_o | output | 1 | Core logic and flash powered |
| ram_on_o | output | 1 | RAM powered |
| ram_stby_o | output | 1 | RAM in retention standby |
| io_hold_o | output | 1 | I/O pin states held |
| io_reset_o | output | 1 | I/O pins forced to reset state |
| osc_on_o | output | 1 | Oscillator enabled |
| reg_stby_o | output | 1 | Regulator in standby |
| cmp_on_o | output | 1 | Analog comparator enabled |
| cpu_rst_o | output | 1 | Reset to the CPU |
| por_o | output | 1 | Reset is power-on equivalent |
| illegal_o | output | 1 | Reset is an illegal-opcode reset |
| stop2_flag_o | output | 1 | A stop2 exit occurred; I/O hold in force |

## Verification
The assertions assume that stop_req arrives as a single-cycle pulse and that configuration bits are stable in the cycle of the request. They also assume that wakeup pins are asynchronous levels, seen only through the synchronizer. The stimulus changes pins and configuration only on falling edges. Before each stop request it parks every pin at the inactive level that the coming mode will use, and leaves the synchronizer several cycles to settle. Between iterations it waits out the reset pulse and the synchronizer so that a stale active level cannot wake the next stop.

// File: rtl/stopseq_pkg.sv
package stopseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STOP1    = 3'd1,
        ST_STOP2    = 3'd2,
        ST_STOP3    = 3'd3,
        ST_WAKE_RST = 3'd4,
        ST_ILL_RST  = 3'd5
    } st_e;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_STOP1 = 2'd1,
        MODE_STOP2 = 2'd2,
        MODE_STOP3 = 2'd3
    } mode_e;

    typedef struct packed {
        logic clk_run;
        logic core_on;
        logic ram_on;
        logic ram_stby;
        logic io_hold;
        logic io_reset;
        logic osc_on;
        logic reg_stby;
        logic cmp_on;
        logic cpu_rst;
        logic por;
        logic illegal;
    } dom_t;

endpackage

// File: rtl/stopseq_mode_sel.sv
module stopseq_mode_sel
    import stopseq_pkg::*;
(
    input  logic stop_en,
    input  logic pd,
    input  logic ppd,
    input  logic lvd_rst_en,
    output st_e  target
);

    // Deep stop is refused while the low-voltage reset is armed: fall back to stop3.
    always_comb begin
        if (!stop_en) begin
            target = ST_ILL_RST;
        end else if (pd && !lvd_rst_en) begin
            target = ppd ? ST_STOP2 : ST_STOP1;
        end else begin
            target = ST_STOP3;
        end
    end

endmodule

// File: rtl/stopseq_wake_sync.sv
module stopseq_wake_sync #(
    parameter int N_KBI       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin,
    input  logic [N_KBI-1:0] kbi_pin,
    input  logic             rst_pin_n,
    input  logic             irq_en,
    input  logic [N_KBI-1:0] kbi_en,
    input  logic             irq_pol_high,
    input  logic             kbi_pol_high,
    input  logic             force_low,
    output logic             wake_int,
    output logic             wake_rst
);

    localparam int N_SRC = N_KBI + 2;

    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] synced;

    assign raw = {rst_pin_n, irq_pin, kbi_pin};

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic [N_SRC-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= raw;
            end
            assign synced = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0][N_SRC-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[SYNC_STAGES-2:0], raw};
            end
            assign synced = s_q[SYNC_STAGES-1];
        end
    endgenerate

    logic             irq_s;
    logic [N_KBI-1:0] kbi_s;
    logic             irq_act;
    logic [N_KBI-1:0] kbi_act;

    assign kbi_s = synced[N_KBI-1:0];
    assign irq_s = synced[N_KBI];

    // In the deepest mode the pins are always low-active.
    always_comb begin
        if (force_low || !irq_pol_high) irq_act = ~irq_s;
        else                            irq_act = irq_s;
        if (force_low || !kbi_pol_high) kbi_act = ~kbi_s;
        else                            kbi_act = kbi_s;
    end

    assign wake_int = (irq_en & irq_act) | (|(kbi_en & kbi_act));
    assign wake_rst = ~synced[N_KBI+1];

endmodule

// File: rtl/stopseq_fsm.sv
module stopseq_fsm
    import stopseq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  st_e  target,
    input  logic wake_int,
    input  logic wake_rst,
    input  logic hold_clr,
    input  logic osc_keep,
    input  logic cmp_keep,
    output st_e  state,
    output logic por_q,
    output logic hold_q,
    output logic osc_q,
    output logic cmp_q
);

    localparam int             CW   = $clog2(RST_CYCLES) + 1;
    localparam logic [CW-1:0]  LAST = CW'(RST_CYCLES - 1);

    st_e           nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req) nxt = target;
            end
            ST_STOP1, ST_STOP2: begin
                if (wake_int || wake_rst) nxt = ST_WAKE_RST;
            end
            ST_STOP3: begin
                if (wake_rst)      nxt = ST_WAKE_RST;
                else if (wake_int) nxt = ST_RUN;
            end
            ST_WAKE_RST, ST_ILL_RST: begin
                if (cnt == LAST) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            por_q  <= 1'b0;
            hold_q <= 1'b0;
            osc_q  <= 1'b0;
            cmp_q  <= 1'b0;
        end else begin
            if (nxt != state)
                cnt <= '0;
            else if (state == ST_WAKE_RST || state == ST_ILL_RST)
                cnt <= cnt + 1'b1;

            if (nxt == ST_WAKE_RST && state != ST_WAKE_RST)
                por_q <= (state == ST_STOP1);
            else if (nxt == ST_RUN)
                por_q <= 1'b0;

            if (state == ST_STOP2 && nxt == ST_WAKE_RST)
                hold_q <= 1'b1;
            else if (hold_clr)
                hold_q <= 1'b0;

            if (state == ST_RUN && nxt == ST_STOP3) begin
                osc_q <= osc_keep;
                cmp_q <= cmp_keep;
            end
        end
    end

endmodule

// File: rtl/stopseq_dom_ctl.sv
module stopseq_dom_ctl
    import stopseq_pkg::*;
(
    input  st_e   state,
    input  logic  por_q,
    input  logic  hold_q,
    input  logic  osc_q,
    input  logic  cmp_q,
    output dom_t  dom,
    output mode_e mode
);

    always_comb begin
        dom  = '0;
        mode = MODE_RUN;
        unique case (state)
            ST_STOP1: begin
                mode         = MODE_STOP1;
                dom.io_reset = 1'b1;
                dom.reg_stby = 1'b1;
            end
            ST_STOP2: begin
                mode         = MODE_STOP2;
                dom.ram_on   = 1'b1;
                dom.ram_stby = 1'b1;
                dom.io_hold  = 1'b1;
                dom.reg_stby = 1'b1;
            end
            ST_STOP3: begin
                mode         = MODE_STOP3;
                dom.core_on  = 1'b1;
                dom.ram_on   = 1'b1;
                dom.ram_stby = 1'b1;
                dom.io_hold  = 1'b1;
                dom.reg_stby = 1'b1;
                dom.osc_on   = osc_q;
                dom.cmp_on   = cmp_q;
            end
            ST_WAKE_RST, ST_ILL_RST: begin
                dom.clk_run  = 1'b1;
                dom.core_on  = 1'b1;
                dom.ram_on   = 1'b1;
                dom.osc_on   = 1'b1;
                dom.cmp_on   = 1'b1;
                dom.io_hold  = hold_q;
                dom.cpu_rst  = 1'b1;
                dom.por      = (state == ST_WAKE_RST) && por_q;
                dom.io_reset = (state == ST_WAKE_RST) && por_q;
                dom.illegal  = (state == ST_ILL_RST);
            end
            default: begin
                dom.clk_run = 1'b1;
                dom.core_on = 1'b1;
                dom.ram_on  = 1'b1;
                dom.osc_on  = 1'b1;
                dom.cmp_on  = 1'b1;
                dom.io_hold = hold_q;
            end
        endcase
    end

endmodule

// File: rtl/stopseq_top.sv
module stopseq_top
    import stopseq_pkg::*;
#(
    parameter int N_KBI       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYCLES  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             cfg_stop_en,
    input  logic             cfg_pd,
    input  logic             cfg_ppd,
    input  logic             cfg_lvd_rst_en,
    input  logic             cfg_osc_keep,
    input  logic             cfg_cmp_keep,
    input  logic             hold_clr,
    input  logic             wake_irq_en,
    input  logic [N_KBI-1:0] wake_kbi_en,
    input  logic             irq_pol_high,
    input  logic             kbi_pol_high,
    input  logic             irq_pin,
    input  logic [N_KBI-1:0] kbi_pin,
    input  logic             rst_pin_n,
    output logic [1:0]       mode_o,
    output logic             clk_run_o,
    output logic             core_on_o,
    output logic             ram_on_o,
    output logic             ram_stby_o,
    output logic             io_hold_o,
    output logic             io_reset_o,
    output logic             osc_on_o,
    output logic             reg_stby_o,
    output logic             cmp_on_o,
    output logic             cpu_rst_o,
    output logic             por_o,
    output logic             illegal_o,
    output logic             stop2_flag_o
);

    st_e   target;
    st_e   state;
    logic  wake_int;
    logic  wake_rst;
    logic  por_q;
    logic  hold_q;
    logic  osc_q;
    logic  cmp_q;
    dom_t  dom;
    mode_e mode;

    stopseq_mode_sel i_mode_sel (
        .stop_en    (cfg_stop_en),
        .pd         (cfg_pd),
        .ppd        (cfg_ppd),
        .lvd_rst_en (cfg_lvd_rst_en),
        .target     (target)
    );

    stopseq_wake_sync #(
        .N_KBI       (N_KBI),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_wake_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pin      (irq_pin),
        .kbi_pin      (kbi_pin),
        .rst_pin_n    (rst_pin_n),
        .irq_en       (wake_irq_en),
        .kbi_en       (wake_kbi_en),
        .irq_pol_high (irq_pol_high),
        .kbi_pol_high (kbi_pol_high),
        .force_low    (state == ST_STOP1),
        .wake_int     (wake_int),
        .wake_rst     (wake_rst)
    );

    stopseq_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .target   (target),
        .wake_int (wake_int),
        .wake_rst (wake_rst),
        .hold_clr (hold_clr),
        .osc_keep (cfg_osc_keep),
        .cmp_keep (cfg_cmp_keep),
        .state    (state),
        .por_q    (por_q),
        .hold_q   (hold_q),
        .osc_q    (osc_q),
        .cmp_q    (cmp_q)
    );

    stopseq_dom_ctl i_dom_ctl (
        .state  (state),
        .por_q  (por_q),
        .hold_q (hold_q),
        .osc_q  (osc_q),
        .cmp_q  (cmp_q),
        .dom    (dom),
        .mode   (mode)
    );

    assign mode_o       = mode;
    assign clk_run_o    = dom.clk_run;
    assign core_on_o    = dom.core_on;
    assign ram_on_o     = dom.ram_on;
    assign ram_stby_o   = dom.ram_stby;
    assign io_hold_o    = dom.io_hold;
    assign io_reset_o   = dom.io_reset;
    assign osc_on_o     = dom.osc_on;
    assign reg_stby_o   = dom.reg_stby;
    assign cmp_on_o     = dom.cmp_on;
    assign cpu_rst_o    = dom.cpu_rst;
    assign por_o        = dom.por;
    assign illegal_o    = dom.illegal;
    assign stop2_flag_o = hold_q;

endmodule

// File: rtl/stopseq_chk.sv
module stopseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       cfg_stop_en,
    input logic       cfg_lvd_rst_en,
    input logic [1:0] mode_o,
    input logic       clk_run_o,
    input logic       core_on_o,
    input logic       ram_on_o,
    input logic       ram_stby_o,
    input logic       io_hold_o,
    input logic       io_reset_o,
    input logic       osc_on_o,
    input logic       cpu_rst_o,
    input logic       por_o,
    input logic       illegal_o,
    input logic       stop2_flag_o
);

    assert_refused_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !cfg_stop_en && mode_o == 2'd0 && !cpu_rst_o)
        |=> (illegal_o && mode_o == 2'd0));

    assert_lvd_interlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && cfg_stop_en && cfg_lvd_rst_en && mode_o == 2'd0 && !cpu_rst_o)
        |=> (mode_o == 2'd3));

    assert_clock_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0) |-> !clk_run_o);

    assert_stop1_domains_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (!core_on_o && !ram_on_o && io_reset_o && !osc_on_o));

    assert_stop2_domains_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!core_on_o && ram_on_o && ram_stby_o && io_hold_o && !osc_on_o));

    assert_por_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_o) |-> ($past(mode_o) == 2'd1));

    assert_stop3_no_por_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> !por_o);

    assert_flag_holds_io_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stop2_flag_o && mode_o != 2'd1) |-> io_hold_o);

endmodule

bind stopseq_top stopseq_chk i_chk (.*);

// File: tb/test_stopseq_top.sv
module test_stopseq_top;

    localparam int NK   = 4;
    localparam int SYN  = 2;
    localparam int RSTC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_req = 1'b0;
    logic          cfg_stop_en = 1'b0, cfg_pd = 1'b0, cfg_ppd = 1'b0, cfg_lvd_rst_en = 1'b0;
    logic          cfg_osc_keep = 1'b0, cfg_cmp_keep = 1'b0, hold_clr = 1'b0;
    logic          wake_irq_en = 1'b1;
    logic [NK-1:0] wake_kbi_en = '1;
    logic          irq_pol_high = 1'b0, kbi_pol_high = 1'b0;
    logic          irq_pin = 1'b1;
    logic [NK-1:0] kbi_pin = '1;
    logic          rst_pin_n = 1'b1;
    logic [1:0]    mode_o;
    logic          clk_run_o, core_on_o, ram_on_o, ram_stby_o, io_hold_o, io_reset_o;
    logic          osc_on_o, reg_stby_o, cmp_on_o, cpu_rst_o, por_o, illegal_o, stop2_flag_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stopseq_top #(.N_KBI(NK), .SYNC_STAGES(SYN), .RST_CYCLES(RSTC)) i_stopseq_top (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_domains(input int m, input bit osck, input bit cmpk);
        chk("R2 mode", mode_o, m);
        chk("R4 clk_run", clk_run_o, 0);
        chk("R5/R6/R7 core_on", core_on_o, m == 3);
        chk("R5/R6/R7 ram_on", ram_on_o, m != 1);
        chk("R5/R6/R7 ram_stby", ram_stby_o, m != 1);
        chk("R5/R6/R7 io_hold", io_hold_o, m != 1);
        chk("R5/R6/R7 io_reset", io_reset_o, m == 1);
        chk("R5/R6/R7 reg_stby", reg_stby_o, 1);
        chk("R7 osc_on", osc_on_o, (m == 3) ? int'(osck) : 0);
        chk("R7 cmp_on", cmp_on_o, (m == 3) ? int'(cmpk) : 0);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input bit en, input bit pd, input bit ppd, input bit lvd,
                           input bit osck, input bit cmpk);
        @(negedge clk);
        cfg_stop_en = en; cfg_pd = pd; cfg_ppd = ppd; cfg_lvd_rst_en = lvd;
        cfg_osc_keep = osck; cfg_cmp_keep = cmpk;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic clear_hold();
        hold_clr = 1'b1;
        @(negedge clk);
        hold_clr = 1'b0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // Reset state, R4
        chk("R4 reset mode", mode_o, 0);
        chk("R4 reset clk_run", clk_run_o, 1);
        chk("R4 reset cpu_rst", cpu_rst_o, 0);
        chk("R12 reset flag", stop2_flag_o, 0);

        for (int c = 0; c < 64; c++) begin
            bit en   = c[0];
            bit pd   = c[1];
            bit ppd  = c[2];
            bit lvd  = c[3];
            bit osck = c[4];
            bit cmpk = c[5];
            bit pol  = c[2] ^ c[4];
            int ws   = c % 3;
            int ki   = (c / 3) % NK;
            int m    = !en ? 0 : (pd && !lvd) ? (ppd ? 2 : 1) : 3;
            bit act  = (m == 1) ? 1'b0 : pol;

            irq_pol_high = pol;
            kbi_pol_high = pol;
            irq_pin = ~act;
            kbi_pin = {NK{~act}};
            rst_pin_n = 1'b1;
            cycles(4);
            request(en, pd, ppd, lvd, osck, cmpk);

            if (m == 0) begin
                chk("R1 illegal", illegal_o, 1);
                chk("R1 cpu_rst", cpu_rst_o, 1);
                chk("R1 mode", mode_o, 0);
                chk("R10 por on illegal", por_o, 0);
                cycles(RSTC);
                chk("R1 illegal end", illegal_o, 0);
                chk("R1 back to run clk", clk_run_o, 1);
            end else begin
                chk_domains(m, osck, cmpk);
                if (ws == 0)      irq_pin = act;
                else if (ws == 1) kbi_pin[ki] = act;
                else              rst_pin_n = 1'b0;
                cycles(SYN + 1);
                if (m == 3 && ws != 2) begin
                    chk("R11 resume mode", mode_o, 0);
                    chk("R11 resume no rst", cpu_rst_o, 0);
                    chk("R11 resume clk", clk_run_o, 1);
                end else begin
                    chk("R8 wake rst", cpu_rst_o, 1);
                    chk("R10 por", por_o, m == 1);
                    chk("R10 io_reset", io_reset_o, m == 1);
                    chk("R12 flag", stop2_flag_o, m == 2);
                    chk("R11/R12 mode", mode_o, 0);
                end
                irq_pin = ~act;
                kbi_pin = {NK{~act}};
                rst_pin_n = 1'b1;
                cycles(RSTC + 4);
                chk("R10 rst released", cpu_rst_o, 0);
                if (m == 2) begin
                    chk("R12 flag in run", stop2_flag_o, 1);
                    chk("R12 hold in run", io_hold_o, 1);
                    clear_hold();
                    chk("R12 flag cleared", stop2_flag_o, 0);
                    chk("R12 hold cleared", io_hold_o, 0);
                end
            end
        end

        // R9: stop1 ignores configured high polarity; a high level does not wake
        irq_pol_high = 1'b1; kbi_pol_high = 1'b1;
        irq_pin = 1'b1; kbi_pin = '1;
        cycles(4);
        request(1, 1, 0, 0, 0, 0);
        chk("R9 in stop1", mode_o, 1);
        cycles(6);
        chk("R9 high level no wake", mode_o, 1);
        irq_pin = 1'b0;
        cycles(SYN + 1);
        chk("R9 low wakes stop1", por_o, 1);
        irq_pin = 1'b1;
        cycles(RSTC + 4);

        // R8 and R7: disabled sources, latency, entry-time latch of keep bits
        irq_pol_high = 1'b0; kbi_pol_high = 1'b0;
        wake_irq_en = 1'b0; wake_kbi_en = 4'b0001;
        cycles(4);
        request(1, 0, 0, 0, 1, 1);
        chk("R7 osc kept", osc_on_o, 1);
        cfg_osc_keep = 1'b0; cfg_cmp_keep = 1'b0;
        cycles(2);
        chk("R7 osc latched", osc_on_o, 1);
        chk("R7 cmp latched", cmp_on_o, 1);
        irq_pin = 1'b0;
        cycles(6);
        chk("R8 disabled irq", mode_o, 3);
        kbi_pin[1] = 1'b0;
        cycles(6);
        chk("R8 disabled kbi", mode_o, 3);
        kbi_pin[0] = 1'b0;
        cycles(SYN);
        chk("R8 latency not yet", mode_o, 3);
        cycles(1);
        chk("R8 latency woke", mode_o, 0);
        chk("R11 no reset", cpu_rst_o, 0);
        irq_pin = 1'b1; kbi_pin = '1;
        cycles(4);

        // R3 explicit: both deep encodings fall back under low-voltage reset
        request(1, 1, 1, 1, 0, 0);
        chk("R3 stop2 blocked", mode_o, 3);
        rst_pin_n = 1'b0;
        cycles(SYN + 1);
        chk("R11 reset pin rst", cpu_rst_o, 1);
        chk("R11 reset pin no por", por_o, 0);
        rst_pin_n = 1'b1;
        cycles(RSTC + 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule